// File: doc/BRIEF.md
# Vectored Interrupt Flag Controller

This block gathers the five interrupt sources of an 8-bit handheld console processor and turns them into a single prioritised request:

- frame blank
- display status
- timer overflow
- serial transfer done
- a keypad press

Each source pulse latches a bit in a flag register. A byte-wide enable register masks the flags. The highest-priority request that is both flagged and enabled is presented to the processor together with its fixed jump address.

The keypad source has no pulse of its own. A request is raised when any of the four keypad lines falls from high to low.

The processor reaches the two registers through a simple byte bus:

- **Flag register:** address 0xFF0F.
- **Enable register:** address 0xFFFF.

Both registers can be read and written. When the processor takes the interrupt, it pulses an acknowledge input, which clears the flag of the vector on offer at that moment. Master-enable handling and return-address stacking belong to the processor core.

Top module: `irqc_top`

## Requirements
- R1: After reset the flag register reads 0xE0, the enable register reads 0x00, `irq_req` is 0 and `irq_vector` is 0x0000.
- R2: A one-cycle pulse on `src_pulse[i]` sets flag bit i at the next rising edge. The bit map is: bit 0 frame blank, bit 1 display status, bit 2 timer overflow, bit 3 serial done. A flag stays set until it is cleared.
- R3: While a request is pending, `irq_vector` is 0x0040 + 8*k for the selected bit k: 0x0040, 0x0048, 0x0050, 0x0058 and 0x0060. With nothing pending it is 0x0000.
- R4: When several enabled flags are pending, the lowest-numbered bit is selected.
- R5: `irq_req` is 1 exactly when the flag bits AND enable bits [4:0] are nonzero. An enable bit of 1 admits its source. A disabled flag stays latched but raises no request. Enable bits [7:5] have no effect on the request.
- R6: A high-to-low transition on any of the four `key_lines` sets flag bit 4 at the edge that samples the low level. A low-to-high transition sets nothing.
- R7: A source pulse sets its flag even when, in the same cycle, the processor writes 0 to that bit of the flag register.
- R8: `irq_ack` high at a rising edge clears only the flag of the vector presented in that cycle. With no request pending it changes nothing.
- R9: Bits [7:5] of the flag register always read as 1, and writes to them are ignored. Bits [4:0] take the written value. All 8 bits of the enable register are stored and read back.
- R10: A bus write to any address other than 0xFF0F or 0xFFFF leaves both registers unchanged. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 4 | Source pulses: frame blank, display status, timer, serial (bits 0..3) |
| key_lines | input | 4 | Keypad input lines, active low |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | Acknowledge of the presented vector |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vector | output | 16 | Jump address of the selected request |

## Verification
A table of single-source and multi-source pulse masks is run against different enable bytes. This separates the bit map and vector table (single sources with everything enabled) from priority (several pending) and from masking (some or all disabled, upper enable bits set).

An acknowledge chain with all five flags pending walks the vectors in order, showing that each acknowledge removes exactly one flag.

Directed cases then cover:
- a falling versus a rising keypad edge, telling edge detection from level detection;
- a source pulse coinciding with a clearing write;
- writes to the constant flag bits;
- bus traffic to unmapped addresses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_N    = 5;
  localparam int EXT_N    = SRC_N - 1;
  localparam int IDX_W    = $clog2(SRC_N);
  localparam int VEC_W    = 16;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0040;
  localparam int VEC_STEP = 8;
  localparam logic [15:0] ADDR_FLAG = 16'hFF0F;
  localparam logic [15:0] ADDR_EN   = 16'hFFFF;

  // Jump address of source index idx
  function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
    return VEC_BASE + VEC_W'(idx * VEC_STEP);
  endfunction

  // Flag register read image: constant ones above the live bits
  function automatic logic [7:0] flag_image(input logic [SRC_N-1:0] f);
    return {{(8-SRC_N){1'b1}}, f};
  endfunction
endpackage

// File: rtl/irqc_key_edge.sv
module irqc_key_edge #(
  parameter int KEY_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_N-1:0] key_lines,
  output logic             key_fall
);
  logic [KEY_N-1:0] prev_q;
  logic [KEY_N-1:0] fell;

  // Cleared at reset so a line held low through reset raises nothing
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= key_lines;
  end

  assign fell     = prev_q & ~key_lines;
  assign key_fall = |fell;
endmodule

// File: rtl/irqc_flag_reg.sv
module irqc_flag_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic         wr_en,
  input  logic [N-1:0] wr_val,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q, flags_d;

  // Order: bus write, then acknowledge clear, then hardware set (set wins)
  always_comb begin
    flags_d = flags_q;
    if (wr_en) flags_d = wr_val;
    flags_d = flags_d & ~clr_mask;
    flags_d = flags_d | hw_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
  import irqc_pkg::*;
#(
  parameter int N = SRC_N
) (
  input  logic [N-1:0]     pending,
  output logic             valid,
  output logic [N-1:0]     sel_onehot,
  output logic [VEC_W-1:0] vector
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] sel_idx;

  // Scan downward so the lowest pending bit is the last one kept
  always_comb begin
    sel_idx = '0;
    valid   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) begin
        sel_idx = IW'(i);
        valid   = 1'b1;
      end
    end
  end

  assign sel_onehot = valid ? (N'(1) << sel_idx) : '0;
  assign vector     = valid ? vec_of(int'(sel_idx)) : '0;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int KEY_N  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_N-1:0]  src_pulse,
  input  logic [KEY_N-1:0]  key_lines,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector
);
  logic              key_fall;
  logic [SRC_N-1:0]  hw_set;
  logic [SRC_N-1:0]  flags;
  logic [SRC_N-1:0]  pending;
  logic [SRC_N-1:0]  sel_onehot;
  logic [SRC_N-1:0]  ack_clr;
  logic              flag_wr;
  logic              en_wr;
  logic [DATA_W-1:0] en_q;

  assign flag_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_FLAG));
  assign en_wr   = bus_wr && (bus_addr == ADDR_W'(ADDR_EN));

  irqc_key_edge #(.KEY_N(KEY_N)) u_key (
    .clk(clk), .rst_n(rst_n), .key_lines(key_lines), .key_fall(key_fall)
  );

  assign hw_set  = {key_fall, src_pulse};
  assign ack_clr = irq_ack ? sel_onehot : '0;

  irqc_flag_reg #(.N(SRC_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .wr_en(flag_wr),
    .wr_val(bus_wdata[SRC_N-1:0]), .clr_mask(ack_clr), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= bus_wdata;
  end

  assign pending = flags & en_q[SRC_N-1:0];

  irqc_prio_enc #(.N(SRC_N)) u_prio (
    .pending(pending), .valid(irq_req), .sel_onehot(sel_onehot), .vector(irq_vector)
  );

  always_comb begin
    if (bus_addr == ADDR_W'(ADDR_FLAG))    bus_rdata = DATA_W'(flag_image(flags));
    else if (bus_addr == ADDR_W'(ADDR_EN)) bus_rdata = en_q;
    else                                   bus_rdata = '0;
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int N = SRC_N
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_ack,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vector,
  input logic [N-1:0]     flags,
  input logic [N-1:0]     pending,
  input logic [N-1:0]     hw_set,
  input logic [N-1:0]     sel_onehot,
  input logic             flag_wr,
  input logic             key_fall
);
  assert_req_matches_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (pending != '0));

  assert_vector_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector[2:0] == 3'b000 && irq_vector >= 16'h0040 && irq_vector <= 16'h0060));

  assert_vector_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vector == '0);

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_onehot));

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (((sel_onehot & pending) == sel_onehot) && (((sel_onehot - N'(1)) & pending) == '0)));

  assert_hw_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set)));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !flag_wr && ((hw_set & sel_onehot) == '0))
      |=> ((flags & $past(sel_onehot)) == '0));

  assert_key_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_fall |=> flags[N-1]);
endmodule

bind irqc_top irqc_checker #(.N(irqc_pkg::SRC_N)) u_irqc_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_req(irq_req),
  .irq_vector(irq_vector), .flags(flags), .pending(pending), .hw_set(hw_set),
  .sel_onehot(sel_onehot), .flag_wr(flag_wr), .key_fall(key_fall)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 9;

  // {src mask[3:0], enable[7:0], expected req, expected vector[15:0]}
  localparam logic [28:0] VECS [NVEC] = '{
    {4'h1, 8'h1F, 1'b1, 16'h0040},
    {4'h2, 8'h1F, 1'b1, 16'h0048},
    {4'h4, 8'h1F, 1'b1, 16'h0050},
    {4'h8, 8'h1F, 1'b1, 16'h0058},
    {4'hF, 8'h00, 1'b0, 16'h0000},
    {4'hF, 8'h0C, 1'b1, 16'h0050},
    {4'h6, 8'h18, 1'b0, 16'h0000},
    {4'hA, 8'h0A, 1'b1, 16'h0048},
    {4'h8, 8'hE8, 1'b1, 16'h0058}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  src_pulse = '0;
  logic [3:0]  key_lines = 4'hF;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_ack = 0;
  logic        irq_req;
  logic [15:0] irq_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .key_lines(key_lines),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    src_pulse = m;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic ack_once();
    @(negedge clk);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0x%04h expected 0x%04h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_read(16'hFF0F, rd); check("R1 flag reset", 16'(rd), 16'h00E0);
    bus_read(16'hFFFF, rd); check("R1 enable reset", 16'(rd), 16'h0000);
    check("R1 req reset", 16'(irq_req), 16'h0000);
    check("R1 vector reset", irq_vector, 16'h0000);

    // Table walk: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0]  m;
      logic [7:0]  en;
      logic        er;
      logic [15:0] ev;
      {m, en, er, ev} = VECS[v];
      bus_write(16'hFF0F, 8'h00);
      bus_write(16'hFFFF, en);
      pulse(m);
      bus_read(16'hFF0F, rd);
      check("R2 flag latch", 16'(rd), 16'(8'hE0 | 8'(m)));
      check("R5 request", 16'(irq_req), 16'(er));
      check("R3 R4 vector", irq_vector, ev);
    end

    // R6 keypad falling edge sets bit 4, vector 0x0060
    bus_write(16'hFF0F, 8'h00);
    bus_write(16'hFFFF, 8'h10);
    @(negedge clk); key_lines = 4'h7;
    @(negedge clk);
    bus_read(16'hFF0F, rd); check("R6 key fall flag", 16'(rd), 16'h00F0);
    check("R3 key vector", irq_vector, 16'h0060);
    bus_write(16'hFF0F, 8'h00);
    @(negedge clk); key_lines = 4'hF;
    @(negedge clk);
    bus_read(16'hFF0F, rd); check("R6 key rise ignored", 16'(rd), 16'h00E0);

    // R8 acknowledge chain, lowest first
    bus_write(16'hFFFF, 8'h1F);
    @(negedge clk); src_pulse = 4'hF; key_lines = 4'hE;
    @(negedge clk); src_pulse = 4'h0;
    check("R4 all pending", irq_vector, 16'h0040);
    ack_once(); check("R8 after ack 1", irq_vector, 16'h0048);
    bus_read(16'hFF0F, rd); check("R8 only one cleared", 16'(rd), 16'h00FE);
    ack_once(); check("R8 after ack 2", irq_vector, 16'h0050);
    ack_once(); check("R8 after ack 3", irq_vector, 16'h0058);
    ack_once(); check("R8 after ack 4", irq_vector, 16'h0060);
    ack_once(); check("R8 after ack 5", 16'(irq_req), 16'h0000);
    key_lines = 4'hF;
    // ack with nothing pending but a disabled flag latched
    bus_write(16'hFFFF, 8'h00);
    pulse(4'h2);
    ack_once();
    bus_read(16'hFF0F, rd); check("R8 idle ack no effect", 16'(rd), 16'h00E2);

    // R7 hardware set beats a clearing write in the same cycle
    @(negedge clk);
    bus_addr = 16'hFF0F; bus_wdata = 8'h00; bus_wr = 1; src_pulse = 4'h4;
    @(negedge clk);
    bus_wr = 0; src_pulse = 4'h0;
    bus_read(16'hFF0F, rd); check("R7 set wins over write", 16'(rd), 16'h00E4);

    // R9 constant bits and enable width
    bus_write(16'hFF0F, 8'h0A);
    bus_read(16'hFF0F, rd); check("R9 flag write 0x0A", 16'(rd), 16'h00EA);
    bus_write(16'hFF0F, 8'hFF);
    bus_read(16'hFF0F, rd); check("R9 flag write 0xFF", 16'(rd), 16'h00FF);
    bus_write(16'hFFFF, 8'hA5);
    bus_read(16'hFFFF, rd); check("R9 enable readback", 16'(rd), 16'h00A5);

    // R10 unmapped addresses
    bus_write(16'hFF0F, 8'h00);
    bus_write(16'h1234, 8'hFF);
    bus_write(16'hFF10, 8'h1F);
    bus_read(16'hFF0F, rd); check("R10 flag untouched", 16'(rd), 16'h00E0);
    bus_read(16'hFFFF, rd); check("R10 enable untouched", 16'(rd), 16'h00A5);
    bus_read(16'h1234, rd); check("R10 unmapped read", 16'(rd), 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule